// File: doc/BRIEF.md
# Integer ALU with Operation-Class Decoder

This block is the arithmetic and logic unit of a single-cycle 32-bit integer datapath, together with the small decoder that chooses its operation. The main instruction decoder supplies a 2-bit operation class. Two classes force a fixed operation. Memory accesses always add, which forms a base-plus-offset address. Conditional branches always subtract, so that the zero output shows whether the two operands are equal. The arithmetic class hands the choice to the instruction's 3-bit function field and to bit 5 of its 7-bit function field.

The whole block is combinational. The result and the zero flag follow the inputs within the same cycle. Results wrap modulo 2^32, and no carry, overflow or exception is produced. A flag marks immediate-form instructions. For those, the subtract selection is suppressed, because immediate arithmetic has no subtract form.

Inside the block every operation has a fixed 4-bit code: AND 0000, OR 0001, add 0010, subtract 0110, XOR 0011, shift-left 0100, logical shift-right 0101, arithmetic shift-right 0111 and set-less-than 1000.

Top module: `int_alu`

## Requirements
- R1: With op_class 00 the result is opnd_a + opnd_b, whatever the function fields and imm_form are.
- R2: With op_class 01 the result is opnd_a - opnd_b, and zero is 1 exactly when opnd_a equals opnd_b.
- R3: With op_class 10, imm_form 0 and fn3 000, the result is opnd_a - opnd_b when fn7_b5 is 1 and opnd_a + opnd_b when fn7_b5 is 0.
- R4: With op_class 10, imm_form 1 and fn3 000, the result is always opnd_a + opnd_b, even when fn7_b5 is 1.
- R5: With op_class 10 the logic operations are AND for fn3 111, OR for fn3 110 and XOR for fn3 100.
- R6: With op_class 10, fn3 001 shifts opnd_a left. fn3 101 shifts it right, logically when fn7_b5 is 0 and arithmetically when fn7_b5 is 1. This holds in both register and immediate form, and the shift amount is opnd_b[4:0].
- R7: With op_class 10 and fn3 010, result bit 0 is 1 when opnd_a is less than opnd_b as signed two's-complement values, and all other result bits are 0.
- R8: Add and subtract wrap modulo 2^32 with no other indication.
- R9: zero is 1 exactly when the result is all zeros, for every operation.
- R10: op_class 11, and fn3 011 with op_class 10, both give opnd_a + opnd_b.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_class | input | 2 | Operation class from the main decoder (00 memory, 01 branch, 10 arithmetic) |
| fn3 | input | 3 | 3-bit function field of the instruction |
| fn7_b5 | input | 1 | Bit 5 of the 7-bit function field |
| imm_form | input | 1 | High for immediate-form arithmetic |
| opnd_a | input | XLEN | First operand |
| opnd_b | input | XLEN | Second operand or immediate |
| result | output | XLEN | Operation result |
| zero | output | 1 | High when the result is zero |

## Verification
The bench builds the block with its default XLEN of 32. It sweeps every combination of class, function field, bit 5 and immediate flag over a grid of operand pairs, including 0, 1, 0x7FFFFFFF, 0x80000000 and 0xFFFFFFFF, and then applies random operands. The grid reaches the signed boundary for set-less-than and the wrap points for add and subtract. Shift amounts above 31 appear in the second operand, so that only the low five bits take effect.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;
    typedef enum logic [3:0] {
        OP_AND = 4'b0000,
        OP_OR  = 4'b0001,
        OP_ADD = 4'b0010,
        OP_XOR = 4'b0011,
        OP_SLL = 4'b0100,
        OP_SRL = 4'b0101,
        OP_SUB = 4'b0110,
        OP_SRA = 4'b0111,
        OP_SLT = 4'b1000
    } alu_op_e;

    typedef enum logic [1:0] {
        CLS_MEM   = 2'b00,
        CLS_BRANCH = 2'b01,
        CLS_ARITH = 2'b10,
        CLS_RSVD  = 2'b11
    } op_class_e;
endpackage

// File: rtl/int_alu_dec.sv
module int_alu_dec
    import int_alu_pkg::*;
(
    input  logic [1:0] op_class,
    input  logic [2:0] fn3,
    input  logic       fn7_b5,
    input  logic       imm_form,
    output alu_op_e    alu_op
);
    alu_op_e arith_op;

    always_comb begin
        unique case (fn3)
            3'b000:  arith_op = (fn7_b5 && !imm_form) ? OP_SUB : OP_ADD;
            3'b001:  arith_op = OP_SLL;
            3'b010:  arith_op = OP_SLT;
            3'b100:  arith_op = OP_XOR;
            3'b101:  arith_op = fn7_b5 ? OP_SRA : OP_SRL;
            3'b110:  arith_op = OP_OR;
            3'b111:  arith_op = OP_AND;
            default: arith_op = OP_ADD;
        endcase
    end

    always_comb begin
        unique case (op_class_e'(op_class))
            CLS_MEM:    alu_op = OP_ADD;
            CLS_BRANCH: alu_op = OP_SUB;
            CLS_ARITH:  alu_op = arith_op;
            default:    alu_op = OP_ADD;
        endcase
    end

    always_comb begin
        if (!$isunknown({op_class, fn3, fn7_b5, imm_form})) begin
            // R4: an immediate form never decodes as subtract
            p_imm_no_sub_r4: assert (!(imm_form && op_class == 2'b10) || alu_op != OP_SUB);
            // R1: the memory class always adds
            p_mem_add_r1: assert (op_class != 2'b00 || alu_op == OP_ADD);
        end
    end
endmodule

// File: rtl/int_alu_shift.sv
module int_alu_shift #(
    parameter int XLEN = 32,
    localparam int SHW = $clog2(XLEN)
) (
    input  logic [XLEN-1:0] din,
    input  logic [SHW-1:0]  amt,
    input  logic            to_left,
    input  logic            arith,
    output logic [XLEN-1:0] dout
);
    function automatic logic [XLEN-1:0] bit_rev(input logic [XLEN-1:0] v);
        logic [XLEN-1:0] r;
        for (int i = 0; i < XLEN; i++) r[i] = v[XLEN-1-i];
        return r;
    endfunction

    logic [XLEN-1:0] stage [0:SHW];
    logic            fill;

    assign fill     = arith & ~to_left & din[XLEN-1];
    assign stage[0] = to_left ? bit_rev(din) : din;

    for (genvar g = 0; g < SHW; g++) begin : g_stage
        localparam int STEP = 1 << g;
        assign stage[g+1] = amt[g] ? {{STEP{fill}}, stage[g][XLEN-1:STEP]} : stage[g];
    end

    assign dout = to_left ? bit_rev(stage[SHW]) : stage[SHW];
endmodule

// File: rtl/int_alu_core.sv
module int_alu_core
    import int_alu_pkg::*;
#(
    parameter int XLEN = 32,
    localparam int SHW = $clog2(XLEN)
) (
    input  alu_op_e         alu_op,
    input  logic [XLEN-1:0] opnd_a,
    input  logic [XLEN-1:0] opnd_b,
    output logic [XLEN-1:0] result,
    output logic            zero
);
    logic [XLEN-1:0] addsub;
    logic [XLEN-1:0] shifted;
    logic            is_sub;
    logic            less;

    assign is_sub = (alu_op == OP_SUB);
    assign addsub = opnd_a + (is_sub ? ~opnd_b : opnd_b) + {{(XLEN-1){1'b0}}, is_sub};
    assign less   = $signed(opnd_a) < $signed(opnd_b);

    int_alu_shift #(.XLEN(XLEN)) u_shift (
        .din    (opnd_a),
        .amt    (opnd_b[SHW-1:0]),
        .to_left(alu_op == OP_SLL),
        .arith  (alu_op == OP_SRA),
        .dout   (shifted)
    );

    always_comb begin
        unique case (alu_op)
            OP_AND:  result = opnd_a & opnd_b;
            OP_OR:   result = opnd_a | opnd_b;
            OP_XOR:  result = opnd_a ^ opnd_b;
            OP_ADD,
            OP_SUB:  result = addsub;
            OP_SLL,
            OP_SRL,
            OP_SRA:  result = shifted;
            OP_SLT:  result = {{(XLEN-1){1'b0}}, less};
            default: result = addsub;
        endcase
    end

    assign zero = ~|result;

    always_comb begin
        if (!$isunknown({alu_op, opnd_a, opnd_b})) begin
            // R7: set-less-than leaves every bit above bit 0 clear
            p_slt_upper_clear_r7: assert (alu_op != OP_SLT || result[XLEN-1:1] == '0);
        end
    end
endmodule

// File: rtl/int_alu.sv
module int_alu
    import int_alu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [1:0]      op_class,
    input  logic [2:0]      fn3,
    input  logic            fn7_b5,
    input  logic            imm_form,
    input  logic [XLEN-1:0] opnd_a,
    input  logic [XLEN-1:0] opnd_b,
    output logic [XLEN-1:0] result,
    output logic            zero
);
    alu_op_e alu_op;

    int_alu_dec u_dec (
        .op_class(op_class),
        .fn3     (fn3),
        .fn7_b5  (fn7_b5),
        .imm_form(imm_form),
        .alu_op  (alu_op)
    );

    int_alu_core #(.XLEN(XLEN)) u_core (
        .alu_op(alu_op),
        .opnd_a(opnd_a),
        .opnd_b(opnd_b),
        .result(result),
        .zero  (zero)
    );

    always_comb begin
        if (!$isunknown({op_class, fn3, fn7_b5, imm_form, opnd_a, opnd_b})) begin
            // R2: on the branch class zero reports operand equality
            p_branch_eq_r2: assert (op_class != 2'b01 || zero == (opnd_a == opnd_b));
            // R1: on the memory class the result is the wrapped sum
            p_mem_sum_r1: assert (op_class != 2'b00 || result == opnd_a + opnd_b);
        end
    end
endmodule

// File: tb/int_alu_tb.sv
`timescale 1ns/1ps
module int_alu_tb;
    localparam int XLEN = 32;
    localparam int WD_CYCLES = 150000;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic [1:0]      op_class;
    logic [2:0]      fn3;
    logic            fn7_b5;
    logic            imm_form;
    logic [XLEN-1:0] opnd_a;
    logic [XLEN-1:0] opnd_b;
    logic [XLEN-1:0] result;
    logic            zero;

    int_alu #(.XLEN(XLEN)) u_dut (
        .op_class(op_class), .fn3(fn3), .fn7_b5(fn7_b5), .imm_form(imm_form),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .result(result), .zero(zero)
    );

    typedef struct {
        logic [XLEN-1:0] exp;
        logic [XLEN-1:0] a;
        logic [XLEN-1:0] b;
        string           tag;
    } item_t;

    item_t sb_q[$];
    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    function automatic logic [XLEN-1:0] ref_calc(input logic [1:0] c, input logic [2:0] f3,
            input logic f75, input logic im, input logic [XLEN-1:0] a, input logic [XLEN-1:0] b);
        if (c == 2'b01) return a - b;
        if (c != 2'b10) return a + b;
        case (f3)
            3'b000:  return (f75 && !im) ? a - b : a + b;
            3'b001:  return a << b[4:0];
            3'b010:  return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
            3'b100:  return a ^ b;
            3'b101:  return f75 ? $unsigned($signed(a) >>> b[4:0]) : a >> b[4:0];
            3'b110:  return a | b;
            3'b111:  return a & b;
            default: return a + b;
        endcase
    endfunction

    function automatic string req_tag(input logic [1:0] c, input logic [2:0] f3,
            input logic f75, input logic im);
        if (c == 2'b00) return "R1";
        if (c == 2'b01) return "R2";
        if (c == 2'b11) return "R10";
        case (f3)
            3'b000:  return im ? "R4" : "R3";
            3'b001, 3'b101: return "R6";
            3'b010:  return "R7";
            3'b100, 3'b110, 3'b111: return "R5";
            default: return "R10";
        endcase
    endfunction

    task automatic apply(input logic [1:0] c, input logic [2:0] f3, input logic f75,
            input logic im, input logic [XLEN-1:0] a, input logic [XLEN-1:0] b, input string tag);
        item_t it;
        @(posedge clk);
        #1;
        op_class = c; fn3 = f3; fn7_b5 = f75; imm_form = im; opnd_a = a; opnd_b = b;
        it.exp = ref_calc(c, f3, f75, im, a, b);
        it.a = a; it.b = b; it.tag = tag;
        sb_q.push_back(it);
    endtask

    // monitor: compares at the falling edge, away from the driving edge
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            n_vec++;
            if (result !== it.exp) begin
                n_fail++;
                $display("FAIL %s a=%h b=%h result actual=%h expected=%h", it.tag, it.a, it.b, result, it.exp);
            end else if (zero !== (it.exp == '0)) begin
                n_fail++;
                $display("FAIL R9 (%s) a=%h b=%h zero actual=%b expected=%b", it.tag, it.a, it.b, zero, it.exp == '0);
            end
        end
    end

    logic [XLEN-1:0] corner [8] = '{32'h0, 32'h1, 32'h7FFF_FFFF, 32'h8000_0000,
                                    32'hFFFF_FFFF, 32'h0000_001F, 32'h0000_0025, 32'h1234_5678};

    initial begin
        op_class = 2'b00; fn3 = 3'b000; fn7_b5 = 1'b0; imm_form = 1'b0; opnd_a = '0; opnd_b = '0;
        // R8: wrap-around cases
        apply(2'b00, 3'b000, 1'b0, 1'b0, 32'h7FFF_FFFF, 32'h1, "R8");
        apply(2'b00, 3'b000, 1'b0, 1'b0, 32'hFFFF_FFFF, 32'h1, "R8");
        apply(2'b01, 3'b000, 1'b0, 1'b0, 32'h0, 32'h1, "R8");
        // R9: equal operands on a branch give zero
        apply(2'b01, 3'b111, 1'b1, 1'b1, 32'hDEAD_BEEF, 32'hDEAD_BEEF, "R9");
        // R4: immediate with the subtract bit set still adds
        apply(2'b10, 3'b000, 1'b1, 1'b1, 32'd10, 32'd3, "R4");
        // full sweep of controls over the corner grid
        for (int c = 0; c < 4; c++)
            for (int f = 0; f < 8; f++)
                for (int s = 0; s < 2; s++)
                    for (int m = 0; m < 2; m++)
                        for (int i = 0; i < 8; i++)
                            for (int j = 0; j < 8; j++)
                                apply(c[1:0], f[2:0], s[0], m[0], corner[i], corner[j],
                                      req_tag(c[1:0], f[2:0], s[0], m[0]));
        // random operands and controls
        for (int k = 0; k < 3000; k++) begin
            logic [1:0] c; logic [2:0] f; logic s, m;
            c = 2'($urandom); f = 3'($urandom); s = 1'($urandom); m = 1'($urandom);
            apply(c, f, s, m, $urandom, $urandom, req_tag(c, f, s, m));
        end
        @(posedge clk);
        @(posedge clk);
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog expired: actual=hung expected=completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end
endmodule